// File: doc/BRIEF.md
# Seven-Line Vectored Interrupt Requester

This block sits on the device side of a processor interrupt link. The processor has one level-sensitive interrupt request input and an active-low acknowledge strobe. Seven peripheral request lines, all active low, come into the block. Each request seen on a clock edge is latched. The block holds its interrupt output high for as long as any latched request remains.

When the processor acknowledges, the block captures the latched requests as a vector byte. It drives that byte, with an output enable, for the whole time the acknowledge is low. The top bit of the byte is always 1. Each lower bit is the active-low state of one request line, so a mix of simultaneous requests produces its own vector number and no priority encoding takes place. When the acknowledge ends, the block drops the requests it reported and keeps any that arrived later. The pads turn the data byte and its enable into a three-state bus driver.

Both the request lines and the acknowledge pass through a two-stage synchronizer before any logic uses them. Reset is synchronous and active high.

Top module: `irq_vector_requester`

## Requirements
- R1: A request line (index 0..6) that is low at a rising clock edge is latched. The interrupt output rises at the third rising edge after the line first goes low, two of those edges being synchronizer delay.
- R2: The interrupt output is high whenever at least one request is latched and low when none is.
- R3: Vector encoding: bit 7 is 1, and bit i (i = 0..6) is 0 exactly when request i was latched at capture time, 1 otherwise. For example, lines 0 and 1 together give FCh, line 0 alone gives FEh, and no request gives FFh.
- R4: A low pulse that lasts one clock period is latched. The interrupt output stays high after the line returns high, until an acknowledge clears it.
- R5: A latched request stays latched until an acknowledge that reported it ends. A request latched while the acknowledge is low is absent from the vector being driven and stays pending afterwards.
- R6: The output enable rises at the third rising edge after the acknowledge falls and drops at the third rising edge after it rises. While the enable is low, the data byte is 00h.
- R7: The vector is captured once, when the acknowledge falls, and stays unchanged while the enable is high, even if the request lines change.
- R8: When the acknowledge rises, the requests it reported are cleared. A line still held low at that point is latched again at once.
- R9: Synchronous reset clears all latched requests, the interrupt output, the output enable and the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 7 | Request lines, active low |
| ack_n | input | 1 | Processor acknowledge, active low |
| irq | output | 1 | Level interrupt request to processor |
| vec_data | output | 8 | Vector byte (00h when not enabled) |
| vec_oe | output | 1 | Enable for the vector bus driver |

## Verification
A lost latch bit shows up at the ports in two ways. Either the interrupt output drops before any acknowledge, or a vector bit reads 1 where the bench pulsed that line. Both become visible within three clocks of the pulse. A wrong capture or clear mask appears as a vector byte that differs from the pulsed pattern, as a vector that changes while the enable is high, or as a request that survives or vanishes across an acknowledge. The bench reads the vector on the acknowledge that follows and checks the interrupt output three clocks after the acknowledge rises. Latency faults in the synchronizers move the interrupt or enable edges off their third-edge positions, and the bench samples at exactly those positions.

// File: rtl/vir_pkg.sv
package vir_pkg;
  typedef enum logic [0:0] {
    ACK_IDLE  = 1'b0,
    ACK_DRIVE = 1'b1
  } ack_state_e;
endpackage

// File: rtl/vir_sync.sv
module vir_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[g] <= {W{RST_VAL}};
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/vir_req_latch.sv
module vir_req_latch #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_s_n,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = (pend & ~clr) | ~req_s_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_d;
      irq  <= |pend_d;
    end
  end
endmodule

// File: rtl/vir_ack_ctrl.sv
module vir_ack_ctrl
  import vir_pkg::*;
#(
  parameter int N = 7,
  localparam int VW = N + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_s_n,
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  clr,
  output logic [VW-1:0] vec,
  output logic          oe
);
  ack_state_e   state;
  logic         ack_prev_n;
  logic [N-1:0] reported;
  logic         fall, rise;

  assign fall = ack_prev_n & ~ack_s_n;
  assign rise = ~ack_prev_n & ack_s_n;

  always_comb begin
    clr = '0;
    if (state == ACK_DRIVE && rise) clr = reported;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ACK_IDLE;
      ack_prev_n <= 1'b1;
      reported   <= '0;
      vec        <= '0;
      oe         <= 1'b0;
    end else begin
      ack_prev_n <= ack_s_n;
      case (state)
        ACK_IDLE: if (fall) begin
          state    <= ACK_DRIVE;
          reported <= pend;
          vec      <= {1'b1, ~pend};
          oe       <= 1'b1;
        end
        ACK_DRIVE: if (rise) begin
          state    <= ACK_IDLE;
          reported <= '0;
          vec      <= '0;
          oe       <= 1'b0;
        end
        default: state <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_requester.sv
module irq_vector_requester #(
  parameter int NUM_LINES   = 7,
  parameter int SYNC_STAGES = 2,
  localparam int VEC_W = NUM_LINES + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_n,
  input  logic                 ack_n,
  output logic                 irq,
  output logic [VEC_W-1:0]     vec_data,
  output logic                 vec_oe
);
  logic [NUM_LINES-1:0] req_s_n;
  logic                 ack_s_n;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] clr_mask;

  vir_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_n), .q(req_s_n)
  );

  vir_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_n), .q(ack_s_n)
  );

  vir_req_latch #(.N(NUM_LINES)) u_latch (
    .clk(clk), .rst(rst), .req_s_n(req_s_n), .clr(clr_mask),
    .pend(pend_q), .irq(irq)
  );

  vir_ack_ctrl #(.N(NUM_LINES)) u_ack (
    .clk(clk), .rst(rst), .ack_s_n(ack_s_n), .pend(pend_q),
    .clr(clr_mask), .vec(vec_data), .oe(vec_oe)
  );
endmodule

// File: rtl/irq_vector_requester_checker.sv
module irq_vector_requester_checker #(
  parameter int N = 7
) (
  input logic         clk,
  input logic         rst,
  input logic         irq,
  input logic [N:0]   vec_data,
  input logic         vec_oe,
  input logic [N-1:0] pend,
  input logic [N-1:0] clr
);
  p_vec_top_r3: assert property (@(posedge clk) disable iff (rst)
    vec_oe |-> vec_data[N]);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !vec_oe |-> (vec_data == '0));

  p_vec_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_data));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !vec_oe && pend == '0));

  p_pend_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (|(pend & ~clr)) |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));

  p_irq_level_r2: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> irq);

  p_clear_only_oe_r8: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |-> vec_oe);
endmodule

bind irq_vector_requester irq_vector_requester_checker #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .vec_data(vec_data), .vec_oe(vec_oe),
  .pend(pend_q), .clr(clr_mask)
);

// File: tb/tb_irq_vector_requester.sv
`timescale 1ns/1ps
module tb_irq_vector_requester;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req_n = 7'h7F;
  logic       ack_n = 1'b1;
  logic       irq;
  logic [7:0] vec_data;
  logic       vec_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  irq_vector_requester dut (
    .clk(clk), .rst(rst), .req_n(req_n), .ack_n(ack_n),
    .irq(irq), .vec_data(vec_data), .vec_oe(vec_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_vec(input logic [6:0] active);
    return {1'b1, ~active};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [6:0] act, input int len);
    req_n = ~act;
    cyc(len);
    req_n = 7'h7F;
  endtask

  task automatic ack_begin();
    ack_n = 1'b0;
    cyc(4);
  endtask

  task automatic ack_end();
    ack_n = 1'b1;
    cyc(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [6:0] pat;
    logic [6:0] late;
    void'($urandom(32'd20240611));
    cyc(3);
    // R9 reset state
    chk("R9 irq after reset", irq, 0);
    chk("R9 oe after reset", vec_oe, 0);
    chk("R9 data after reset", vec_data, 8'h00);
    rst = 1'b0;
    cyc(2);

    // R1 latency: line 3 low before edge k, irq at edge k+2
    req_n = 7'h77;
    cyc(2);
    chk("R1 irq not before third edge", irq, 0);
    cyc(1);
    chk("R1 irq at third edge", irq, 1);
    req_n = 7'h7F;
    cyc(4);
    chk("R4 irq held after release", irq, 1);
    // R6 enable latency
    ack_n = 1'b0;
    cyc(2);
    chk("R6 oe not before third edge", vec_oe, 0);
    chk("R6 data zero while disabled", vec_data, 8'h00);
    cyc(1);
    chk("R6 oe at third edge", vec_oe, 1);
    chk("R3 vector line3", vec_data, 8'hF7);
    ack_n = 1'b1;
    cyc(2);
    chk("R6 oe held until third edge", vec_oe, 1);
    cyc(1);
    chk("R6 oe drops", vec_oe, 0);
    chk("R8 irq cleared", irq, 0);
    chk("R6 data zero after", vec_data, 8'h00);

    // R3 combined vector FCh, single-period pulses (R4)
    pulse(7'h01, 1);
    pulse(7'h02, 1);
    cyc(4);
    chk("R4 one-period pulses latched", irq, 1);
    ack_begin();
    chk("R3 lines0+1 vector", vec_data, 8'hFC);
    // R7 stability while lines change; R5 late request
    pulse(7'h04, 2);
    cyc(4);
    chk("R7 vector stable", vec_data, 8'hFC);
    ack_end();
    chk("R5 late request keeps irq", irq, 1);
    ack_begin();
    chk("R5 late request in next vector", vec_data, 8'hFB);
    ack_end();
    chk("R8 cleared after second ack", irq, 0);

    // R3 empty ack gives FFh
    ack_begin();
    chk("R3 empty vector", vec_data, 8'hFF);
    ack_end();

    // R8 line still held low at ack end relatches
    req_n = 7'h3F;
    cyc(4);
    ack_begin();
    chk("R3 line6 vector", vec_data, 8'hBF);
    ack_end();
    chk("R8 held line relatched", irq, 1);
    req_n = 7'h7F;
    cyc(3);
    ack_begin();
    chk("R8 relatched vector", vec_data, 8'hBF);
    ack_end();
    chk("R8 cleared after release", irq, 0);

    // R9 reset mid-pending
    pulse(7'h55, 2);
    cyc(4);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(4);
    chk("R9 reset drops pending", irq, 0);
    ack_begin();
    chk("R9 no vector bits after reset", vec_data, 8'hFF);
    ack_end();

    // random patterns
    for (int it = 0; it < 40; it++) begin
      pat  = 7'($urandom);
      late = 7'($urandom) & ~pat;
      pulse(pat, 1 + ($urandom % 3));
      cyc(4);
      chk("R2 irq reflects latched", irq, (pat != 0));
      ack_begin();
      chk("R3 random vector", vec_data, exp_vec(pat));
      chk("R6 oe random", vec_oe, 1);
      if (late != 0) begin
        pulse(late, 1);
        cyc(3);
      end
      chk("R7 random stable", vec_data, exp_vec(pat));
      ack_end();
      chk("R5 irq after ack", irq, (late != 0));
      if (late != 0) begin
        ack_begin();
        chk("R5 late vector", vec_data, exp_vec(late));
        ack_end();
        chk("R8 irq after late ack", irq, 0);
      end
    end
    finish_run();
  end
endmodule